// File: doc/BRIEF.md
# GPIO Group Interrupt and Wake Event Controller

This block watches a group of up to 24 GPIO input pads and turns activity on them into interrupt and wake requests. Each pad passes through a two-flop synchronizer. A per-pad configuration word then selects whether the pad reacts to a level, to a single edge, to both edges, or to nothing. A per-pad inversion bit turns rising into falling and high into low. A detected event sets that pad's interrupt status bit, but only if the host owns the pad. The same event also sets the pad's wake status bit.

Software uses a word-addressed 32-bit read/write port to enable interrupts and wake per pad, to clear status bits by writing ones, and to program each pad's configuration. One combined interrupt line is raised from pending and enabled status bits. One wake line is raised from pending and enabled wake bits, except on pads that are routed to the system-control interrupt instead.

Top module: `gpio_evt_group`

## Requirements
- R1: After reset every register reads 0, and `irq` and `wake` are low. The word address map is: 0 interrupt status, 1 interrupt enable, 2 wake status, 3 wake enable, 4+p configuration of pad p.
- R2: Pad p always uses bit p of the status, enable, wake status and wake enable registers. Pad p's configuration sits at word 4+p, so the last pad of a 24-pad group is at word 0x1B.
- R3: The configuration word has three fields. Bits [1:0] are the event mode: 0 level, 1 single edge, 2 disabled, 3 both edges. Bit 2 inverts the input. Bit 3 routes the pad to the system-control interrupt. In single-edge mode without inversion, a rising edge sets status and a falling edge does not.
- R4: With inversion set in single-edge mode, a falling edge sets status and a rising edge does not.
- R5: In both-edges mode, a rising edge and a falling edge each set status.
- R6: In level mode, status is set on every clock while the active level is present, so a clear does not hold while that level remains. With inversion set, the active level is low.
- R7: In disabled mode, pad activity sets neither interrupt status nor wake status.
- R8: Writing word 0 clears every status bit written as 1 and leaves bits written as 0 unchanged. The same rule applies to wake status at word 2.
- R9: `irq` is high exactly when some pad has both its status bit and its enable bit set.
- R10: A pad whose `host_own` bit is clear never sets its interrupt status bit, but its events still set its wake status bit.
- R11: `wake` is high exactly when some pad has wake status set, wake enable set, and its system-control routing bit clear.
- R12: Bits at positions NPADS and above read 0 in every register. A configuration word reads back only its four defined bits. Unmapped words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pad_in | input | NPADS | Raw asynchronous pad inputs |
| host_own | input | NPADS | Per-pad host ownership; clear blocks interrupt status updates |
| addr | input | AW | Word address of the register port |
| we | input | 1 | Write strobe |
| wdata | input | DW | Write data |
| rdata | output | DW | Combinational read data for `addr` |
| irq | output | 1 | Combined interrupt request |
| wake | output | 1 | Combined wake request |

## Verification
The hardest case is the level-mode clear race. Software writes a one to clear a status bit while the active level is still present, and the set must win in the same cycle. The stimulus holds a pad high in level mode and issues the clear. It then reads the bit on the very next cycle and expects it still set. Only after the pad is dropped does a second clear stick. Inversion with level mode is reached by rewriting a low pad's configuration, which must set status without any edge occurring.

// File: rtl/gpio_evt_group.sv
module gpio_evt_group #(
  parameter int NPADS    = 24,
  parameter int AW       = 5,
  parameter int DW       = 32,
  parameter int CFG_BASE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPADS-1:0] pad_in,
  input  logic [NPADS-1:0] host_own,
  input  logic [AW-1:0]    addr,
  input  logic             we,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             irq,
  output logic             wake
);
  localparam logic [AW-1:0] A_STS  = AW'(0);
  localparam logic [AW-1:0] A_EN   = AW'(1);
  localparam logic [AW-1:0] A_GSTS = AW'(2);
  localparam logic [AW-1:0] A_GEN  = AW'(3);

  logic [NPADS-1:0] sync1, sync2, prev;
  logic [NPADS-1:0] sts, en, gsts, gen;
  logic [NPADS-1:0] ev, sci_v;
  logic [NPADS-1:0][3:0] cfg;
  logic [NPADS-1:0] wmask;
  logic unused_wbits;

  assign wmask = wdata[NPADS-1:0];
  assign unused_wbits = ^wdata[DW-1:NPADS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= pad_in;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  for (genvar i = 0; i < NPADS; i++) begin : g_pad
    logic cur, old;
    assign cur = sync2[i] ^ cfg[i][2];
    assign old = prev[i] ^ cfg[i][2];
    assign sci_v[i] = cfg[i][3];

    always_comb begin
      case (cfg[i][1:0])
        2'd0:    ev[i] = cur;
        2'd1:    ev[i] = cur & ~old;
        2'd2:    ev[i] = 1'b0;
        default: ev[i] = cur ^ old;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rst_n) cfg[i] <= '0;
      else if (we && addr == AW'(CFG_BASE + i)) cfg[i] <= wdata[3:0];
    end

    p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts[i]) |-> $past(cfg[i][1:0]) != 2'd2);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts  <= '0;
      en   <= '0;
      gsts <= '0;
      gen  <= '0;
    end else begin
      sts  <= (sts  & ~((we && addr == A_STS)  ? wmask : '0)) | (ev & host_own);
      gsts <= (gsts & ~((we && addr == A_GSTS) ? wmask : '0)) | ev;
      if (we && addr == A_EN)  en  <= wmask;
      if (we && addr == A_GEN) gen <= wmask;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_STS:   rdata = DW'(sts);
      A_EN:    rdata = DW'(en);
      A_GSTS:  rdata = DW'(gsts);
      A_GEN:   rdata = DW'(gen);
      default: begin
        for (int k = 0; k < NPADS; k++)
          if (addr == AW'(CFG_BASE + k)) rdata = DW'(cfg[k]);
      end
    endcase
  end

  assign irq  = |(sts & en);
  assign wake = |(gsts & gen & ~sci_v);

  p_owner_gates_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts & ~$past(sts) & ~$past(host_own)) == '0));

  p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|en));

  p_wake_needs_route_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (|(gen & ~sci_v)));

  p_wake_needs_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (|gsts));
endmodule

// File: tb/gpio_evt_group_bench.sv
module gpio_evt_group_bench;
  localparam int NP = 24;
  logic clk = 0, rst_n = 0;
  logic [NP-1:0] pad_in = '0, host_own = '1;
  logic [4:0] addr = '0;
  logic we = 0;
  logic [31:0] wdata = '0, rdata;
  logic irq, wake;
  int total = 0, bad = 0;
  bit done = 0;
  event do_cmp;
  logic [31:0] exp_q[$];
  int sel_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  gpio_evt_group u_gpio_evt_group (.clk(clk), .rst_n(rst_n), .pad_in(pad_in),
    .host_own(host_own), .addr(addr), .we(we), .wdata(wdata), .rdata(rdata),
    .irq(irq), .wake(wake));

  initial forever begin
    @(do_cmp);
    while (exp_q.size() > 0) begin
      logic [31:0] e, act;
      int s;
      string t;
      e = exp_q.pop_front(); s = sel_q.pop_front(); t = tag_q.pop_front();
      act = (s == 0) ? rdata : (s == 1) ? {31'b0, irq} : {31'b0, wake};
      total++;
      if (act !== e) begin
        bad++;
        $display("FAIL %s act=%h exp=%h", t, act, e);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic chk(input int sel, input logic [4:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); addr = a;
    exp_q.push_back(e); sel_q.push_back(sel); tag_q.push_back(tag);
    #1 -> do_cmp;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic pad(input int p, input logic v);
    @(negedge clk); pad_in[p] = v;
    settle();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk(0, 5'h00, 0, "R1 sts"); chk(0, 5'h01, 0, "R1 en");
    chk(0, 5'h02, 0, "R1 gsts"); chk(0, 5'h03, 0, "R1 gen");
    chk(0, 5'h04, 0, "R1 cfg0"); chk(0, 5'h1B, 0, "R1 cfg23");
    chk(1, 0, 0, "R1 irq"); chk(2, 0, 0, "R1 wake");
    // R3 rising edge, R8 write-one-to-clear
    wr(5'h04, 1);
    pad(0, 1); chk(0, 0, 32'h1, "R3 rise sets");
    wr(5'h00, 32'h2); chk(0, 0, 32'h1, "R8 zero bit keeps");
    wr(5'h00, 32'h1); chk(0, 0, 32'h0, "R8 one bit clears");
    pad(0, 0); chk(0, 0, 32'h0, "R3 fall ignored");
    // R4 inverted single edge
    wr(5'h05, 5);
    pad(1, 1); chk(0, 0, 32'h0, "R4 rise ignored");
    pad(1, 0); chk(0, 0, 32'h2, "R4 fall sets");
    wr(5'h00, 32'hFFFFFF);
    // R5 both edges
    wr(5'h06, 3);
    pad(2, 1); chk(0, 0, 32'h4, "R5 rise sets");
    wr(5'h00, 32'h4);
    pad(2, 0); chk(0, 0, 32'h4, "R5 fall sets");
    wr(5'h00, 32'h4);
    // R6 level mode
    pad(3, 1); chk(0, 0, 32'h8, "R6 high sets");
    wr(5'h00, 32'h8); chk(0, 0, 32'h8, "R6 clear lost while high");
    pad(3, 0); wr(5'h00, 32'h8); chk(0, 0, 32'h0, "R6 clear after drop");
    wr(5'h07, 4); settle(); chk(0, 0, 32'h8, "R6 inverted low sets");
    wr(5'h07, 2); wr(5'h00, 32'h8); chk(0, 0, 32'h0, "R6 cleared");
    // R7 disabled
    wr(5'h08, 2); wr(5'h02, 32'hFFFFFF);
    pad(4, 1); pad(4, 0);
    chk(0, 0, 32'h0, "R7 no status"); chk(0, 5'h02, 32'h0, "R7 no wake status");
    // R2 last pad
    wr(5'h1B, 1); chk(0, 5'h1B, 32'h1, "R2 cfg23 readback");
    pad(23, 1); chk(0, 0, 32'h800000, "R2 pad23 bit");
    wr(5'h00, 32'hFFFFFF);
    // R9 irq
    pad(0, 1); chk(1, 0, 0, "R9 irq masked");
    wr(5'h01, 1); chk(1, 0, 1, "R9 irq enabled");
    wr(5'h01, 2); chk(1, 0, 0, "R9 other enable");
    wr(5'h01, 1); wr(5'h00, 1); chk(1, 0, 0, "R9 status cleared");
    wr(5'h01, 0); pad(0, 0);
    // R10 ownership
    @(negedge clk); host_own[5] = 0;
    wr(5'h09, 1); wr(5'h02, 32'hFFFFFF);
    pad(5, 1);
    chk(0, 0, 32'h0, "R10 no status unowned"); chk(0, 5'h02, 32'h20, "R10 wake status kept");
    // R11 wake
    wr(5'h03, 32'h20); chk(2, 0, 1, "R11 wake");
    wr(5'h09, 9); chk(2, 0, 0, "R11 sci routed");
    wr(5'h09, 1); chk(2, 0, 1, "R11 sci cleared");
    wr(5'h02, 32'h20); chk(2, 0, 0, "R11 wake status cleared");
    wr(5'h03, 0);
    // R12 upper bits
    wr(5'h01, 32'hFFFFFFFF); chk(0, 5'h01, 32'h00FFFFFF, "R12 enable width");
    wr(5'h01, 0);
    wr(5'h00, 32'hFF000000); chk(0, 0, 32'h0, "R12 status upper");
    wr(5'h04, 32'hFFFFFFFF); chk(0, 5'h04, 32'hF, "R12 cfg width");
    chk(0, 5'h1C, 0, "R12 unmapped 1C"); chk(0, 5'h1F, 0, "R12 unmapped 1F");
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule